// File: doc/BRIEF.md
# Hashed Layer-2 Address Table

This block is the forwarding database of an Ethernet switch. Each stored entry binds a station address, qualified by a filtering-database number, to the switch port on which the station was last seen. A source address presented on the learn channel is installed, or its existing entry is refreshed. A destination address presented on the search channel returns the stored port, or a flood indication when no entry matches.

The search key is the 48-bit address with the 3-bit database number placed above it. This key is folded with XOR into a set index. Each set holds four ways. The database number is the low three VLAN bits when per-VLAN learning is selected, and zero for every VLAN in shared mode. Dynamic entries carry a 2-bit age that a periodic sweep tick counts down. Static entries are pinned. A host port reads or writes any single way directly. Host accesses run only in cycles that the learn and search channels leave free.

Top module: `l2_addr_table`

## Requirements
- R1: After reset the table is empty, `look_done` and `host_done` are low and `drop_cnt` is zero, so every search floods.
- R2: A search issued with `look_valid` in one cycle produces a one-cycle `look_done` in the next cycle, together with either `look_hit` and the stored port, or `look_flood` with port zero.
- R3: The set index is the XOR fold of the 51-bit key {fid, mac}: key bit i is XORed into index bit (i mod IDX_W). Each set has ways 0 to 3, and the host port addresses entries by that set and way.
- R4: With `ivl_mode`=1 the database number is `vid[2:0]`, so the same address under VLANs 5 and 6 yields separate entries. With `ivl_mode`=0 it is 0 for every VLAN.
- R5: A learn whose key matches a valid dynamic entry rewrites that entry's port and sets its age to 3. Otherwise the learn fills the lowest-numbered free way of the set, with age 3.
- R6: A learn that finds all four ways valid, with none matching its key, stores nothing and increments the saturating `drop_cnt` by one. No other event changes `drop_cnt`.
- R7: A static entry is never changed by a learn and is never aged out.
- R8: Each `age_tick` decrements the age of every valid dynamic entry, and an entry whose age reaches zero becomes invalid. A freshly learned entry therefore survives two ticks and is gone after the third.
- R9: A host write stores valid, static, mac, fid and port at the given set and way, with age 3. A host read returns all fields, including the age. `host_done` pulses for one cycle after the access executes.
- R10: A pending host access waits while `learn_valid` or `look_valid` is high. It executes in the first cycle in which both are low, and `host_done` follows in the next cycle.
- R11: A search and a learn of the same key in the same cycle: the search sees the table as it was before that learn.
- R12: When a learn and an `age_tick` fall in the same cycle, the learned entry starts with age 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ivl_mode | input | 1 | 1: per-VLAN database, 0: shared database |
| age_tick | input | 1 | Aging sweep pulse |
| learn_valid | input | 1 | Learn request |
| learn_mac | input | 48 | Source address to learn |
| learn_vid | input | 12 | VLAN of the learned frame |
| learn_port | input | PORT_W | Ingress port |
| look_valid | input | 1 | Search request |
| look_mac | input | 48 | Destination address to search |
| look_vid | input | 12 | VLAN of the searched frame |
| look_done | output | 1 | Search result strobe |
| look_hit | output | 1 | Search matched |
| look_flood | output | 1 | Search missed, flood |
| look_port | output | PORT_W | Egress port on a hit |
| drop_cnt | output | CNT_W | Learns refused on a full set |
| host_req | input | 1 | Host access request pulse |
| host_wr | input | 1 | 1: write, 0: read |
| host_set | input | IDX_W | Set index |
| host_way | input | 2 | Way within set |
| host_wr_valid | input | 1 | Write data: valid |
| host_wr_static | input | 1 | Write data: static |
| host_wr_mac | input | 48 | Write data: address |
| host_wr_fid | input | FID_W | Write data: database |
| host_wr_port | input | PORT_W | Write data: port |
| host_done | output | 1 | Host access complete |
| host_rd_valid | output | 1 | Read data: valid |
| host_rd_static | output | 1 | Read data: static |
| host_rd_mac | output | 48 | Read data: address |
| host_rd_fid | output | FID_W | Read data: database |
| host_rd_port | output | PORT_W | Read data: port |
| host_rd_age | output | 2 | Read data: age |

## Verification
Two collisions are provoked on purpose. In the first, a learn and a search of the same new address are driven in one cycle. The search must flood, and a second search one cycle later must hit. In the second, a learn is driven in the same cycle as an aging tick, and the entry must then survive exactly two further ticks. Host/traffic contention is provoked by holding a search active while a host read waits. The bench requires `host_done` to stay low until the search drops and to rise one cycle after that.

// File: rtl/l2_addr_table.sv
module l2_addr_table #(
  parameter int SETS   = 64,
  parameter int PORT_W = 3,
  parameter int FID_W  = 3,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAYS  = 4,
  localparam int WAY_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ivl_mode,
  input  logic              age_tick,
  input  logic              learn_valid,
  input  logic [47:0]       learn_mac,
  input  logic [11:0]       learn_vid,
  input  logic [PORT_W-1:0] learn_port,
  input  logic              look_valid,
  input  logic [47:0]       look_mac,
  input  logic [11:0]       look_vid,
  output logic              look_done,
  output logic              look_hit,
  output logic              look_flood,
  output logic [PORT_W-1:0] look_port,
  output logic [CNT_W-1:0]  drop_cnt,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [IDX_W-1:0]  host_set,
  input  logic [WAY_W-1:0]  host_way,
  input  logic              host_wr_valid,
  input  logic              host_wr_static,
  input  logic [47:0]       host_wr_mac,
  input  logic [FID_W-1:0]  host_wr_fid,
  input  logic [PORT_W-1:0] host_wr_port,
  output logic              host_done,
  output logic              host_rd_valid,
  output logic              host_rd_static,
  output logic [47:0]       host_rd_mac,
  output logic [FID_W-1:0]  host_rd_fid,
  output logic [PORT_W-1:0] host_rd_port,
  output logic [1:0]        host_rd_age
);
  localparam int N     = SETS * WAYS;
  localparam int KEY_W = 48 + FID_W;
  localparam int ENT_W = IDX_W + WAY_W;
  localparam logic [1:0] AGE_FULL = 2'd3;

  logic              e_val  [N];
  logic              e_st   [N];
  logic [47:0]       e_mac  [N];
  logic [FID_W-1:0]  e_fid  [N];
  logic [PORT_W-1:0] e_port [N];
  logic [1:0]        e_age  [N];

  function automatic logic [IDX_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < KEY_W; i++) h[i % IDX_W] ^= k[i];
    return h;
  endfunction

  wire [FID_W-1:0] l_fid = ivl_mode ? learn_vid[FID_W-1:0] : '0;
  wire [FID_W-1:0] k_fid = ivl_mode ? look_vid[FID_W-1:0]  : '0;
  wire [IDX_W-1:0] l_set = fold({l_fid, learn_mac});
  wire [IDX_W-1:0] k_set = fold({k_fid, look_mac});

  logic             l_hit, l_free, k_hit;
  logic [WAY_W-1:0] l_hway, l_fway;
  logic [PORT_W-1:0] k_port;

  always_comb begin
    l_hit = 1'b0; l_free = 1'b0; l_hway = '0; l_fway = '0;
    k_hit = 1'b0; k_port = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (e_val[{l_set, WAY_W'(w)}] && e_mac[{l_set, WAY_W'(w)}] == learn_mac &&
          e_fid[{l_set, WAY_W'(w)}] == l_fid) begin
        l_hit  = 1'b1;
        l_hway = WAY_W'(w);
      end
      if (!e_val[{l_set, WAY_W'(w)}]) begin
        l_free = 1'b1;
        l_fway = WAY_W'(w);
      end
      if (e_val[{k_set, WAY_W'(w)}] && e_mac[{k_set, WAY_W'(w)}] == look_mac &&
          e_fid[{k_set, WAY_W'(w)}] == k_fid) begin
        k_hit  = 1'b1;
        k_port = e_port[{k_set, WAY_W'(w)}];
      end
    end
  end

  wire [ENT_W-1:0] l_hidx = {l_set, l_hway};
  wire [ENT_W-1:0] l_fidx = {l_set, l_fway};

  logic              hp_pend, hp_wr, hp_valid, hp_static;
  logic [IDX_W-1:0]  hp_set;
  logic [WAY_W-1:0]  hp_way;
  logic [47:0]       hp_mac;
  logic [FID_W-1:0]  hp_fid;
  logic [PORT_W-1:0] hp_port;

  wire             h_exec = hp_pend && !learn_valid && !look_valid;
  wire [ENT_W-1:0] h_idx  = {hp_set, hp_way};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_val[i]  <= 1'b0;
        e_st[i]   <= 1'b0;
        e_mac[i]  <= '0;
        e_fid[i]  <= '0;
        e_port[i] <= '0;
        e_age[i]  <= '0;
      end
      look_done <= 1'b0; look_hit <= 1'b0; look_flood <= 1'b0; look_port <= '0;
      drop_cnt  <= '0;
      hp_pend <= 1'b0; hp_wr <= 1'b0; hp_valid <= 1'b0; hp_static <= 1'b0;
      hp_set <= '0; hp_way <= '0; hp_mac <= '0; hp_fid <= '0; hp_port <= '0;
      host_done <= 1'b0;
      host_rd_valid <= 1'b0; host_rd_static <= 1'b0; host_rd_mac <= '0;
      host_rd_fid <= '0; host_rd_port <= '0; host_rd_age <= '0;
    end else begin
      look_done  <= look_valid;
      look_hit   <= look_valid && k_hit;
      look_flood <= look_valid && !k_hit;
      look_port  <= (look_valid && k_hit) ? k_port : '0;

      if (age_tick) begin
        for (int i = 0; i < N; i++) begin
          if (e_val[i] && !e_st[i]) begin
            e_age[i] <= e_age[i] - 2'd1;
            if (e_age[i] <= 2'd1) e_val[i] <= 1'b0;
          end
        end
      end

      if (learn_valid) begin
        if (l_hit) begin
          if (!e_st[l_hidx]) begin
            e_port[l_hidx] <= learn_port;
            e_age[l_hidx]  <= AGE_FULL;
            e_val[l_hidx]  <= 1'b1;
          end
        end else if (l_free) begin
          e_val[l_fidx]  <= 1'b1;
          e_st[l_fidx]   <= 1'b0;
          e_mac[l_fidx]  <= learn_mac;
          e_fid[l_fidx]  <= l_fid;
          e_port[l_fidx] <= learn_port;
          e_age[l_fidx]  <= AGE_FULL;
        end else if (drop_cnt != '1) begin
          drop_cnt <= drop_cnt + 1'b1;
        end
      end

      host_done <= h_exec;
      if (h_exec) begin
        hp_pend        <= 1'b0;
        host_rd_valid  <= e_val[h_idx];
        host_rd_static <= e_st[h_idx];
        host_rd_mac    <= e_mac[h_idx];
        host_rd_fid    <= e_fid[h_idx];
        host_rd_port   <= e_port[h_idx];
        host_rd_age    <= e_age[h_idx];
        if (hp_wr) begin
          e_val[h_idx]  <= hp_valid;
          e_st[h_idx]   <= hp_static;
          e_mac[h_idx]  <= hp_mac;
          e_fid[h_idx]  <= hp_fid;
          e_port[h_idx] <= hp_port;
          e_age[h_idx]  <= hp_valid ? AGE_FULL : 2'd0;
        end
      end else if (host_req && !hp_pend) begin
        hp_pend   <= 1'b1;
        hp_wr     <= host_wr;
        hp_set    <= host_set;
        hp_way    <= host_way;
        hp_valid  <= host_wr_valid;
        hp_static <= host_wr_static;
        hp_mac    <= host_wr_mac;
        hp_fid    <= host_wr_fid;
        hp_port   <= host_wr_port;
      end
    end
  end
endmodule

module l2_addr_table_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             learn_valid,
  input logic             look_valid,
  input logic             look_done,
  input logic             look_hit,
  input logic             look_flood,
  input logic             host_done,
  input logic [CNT_W-1:0] drop_cnt
);
  AST_LOOK_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> look_done); // R2
  AST_LOOK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> !look_done); // R2
  AST_HIT_OR_FLOOD: assert property (@(posedge clk) disable iff (!rst_n)
    look_done |-> (look_hit != look_flood)); // R2
  AST_HOST_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(!learn_valid && !look_valid)); // R10
  AST_HOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1)); // R6
  AST_DROP_NEEDS_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
    !learn_valid |=> $stable(drop_cnt)); // R6
endmodule

bind l2_addr_table l2_addr_table_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .learn_valid(learn_valid), .look_valid(look_valid),
  .look_done(look_done), .look_hit(look_hit), .look_flood(look_flood),
  .host_done(host_done), .drop_cnt(drop_cnt)
);

// File: tb/tb_l2_addr_table.sv
`timescale 1ns/1ps
module tb_l2_addr_table;
  localparam int IDX_W = 6;

  logic clk = 0, rst_n = 0, ivl_mode = 1, age_tick = 0;
  logic learn_valid = 0; logic [47:0] learn_mac = 0; logic [11:0] learn_vid = 0; logic [2:0] learn_port = 0;
  logic look_valid = 0;  logic [47:0] look_mac = 0;  logic [11:0] look_vid = 0;
  logic look_done, look_hit, look_flood; logic [2:0] look_port; logic [15:0] drop_cnt;
  logic host_req = 0, host_wr = 0; logic [IDX_W-1:0] host_set = 0; logic [1:0] host_way = 0;
  logic host_wr_valid = 0, host_wr_static = 0; logic [47:0] host_wr_mac = 0;
  logic [2:0] host_wr_fid = 0, host_wr_port = 0;
  logic host_done, host_rd_valid, host_rd_static; logic [47:0] host_rd_mac;
  logic [2:0] host_rd_fid, host_rd_port; logic [1:0] host_rd_age;

  l2_addr_table dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [3:0] expq [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [IDX_W-1:0] hsh(input logic [2:0] fid, input logic [47:0] mac);
    logic [50:0] k; logic [IDX_W-1:0] h;
    k = {fid, mac}; h = '0;
    for (int i = 0; i < 51; i++) h[i % IDX_W] ^= k[i];
    return h;
  endfunction

  always @(negedge clk) begin
    if (rst_n && look_done) begin
      if (expq.size() == 0) chk(0, "R2 unexpected look_done", 1, 0);
      else begin
        logic [3:0] e;
        e = expq.pop_front();
        chk(look_hit == e[3] && look_flood == !e[3] && look_port == e[2:0],
            e[3] ? "R2 lookup hit/port" : "R2 lookup flood",
            {look_hit, look_flood, look_port}, {e[3], !e[3], e[2:0]});
      end
    end
  end

  task automatic op(input bit lv, input logic [47:0] lm, input logic [11:0] lvd, input logic [2:0] lp,
                    input bit kv, input logic [47:0] km, input logic [11:0] kvd,
                    input bit tk, input bit eh, input logic [2:0] ep);
    @(negedge clk);
    learn_valid = lv; learn_mac = lm; learn_vid = lvd; learn_port = lp;
    look_valid = kv; look_mac = km; look_vid = kvd; age_tick = tk;
    if (kv) expq.push_back({eh, eh ? ep : 3'd0});
    @(negedge clk);
    learn_valid = 0; look_valid = 0; age_tick = 0;
  endtask

  task automatic learn(input logic [47:0] m, input logic [11:0] v, input logic [2:0] p);
    op(1, m, v, p, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic look(input logic [47:0] m, input logic [11:0] v, input bit eh, input logic [2:0] ep);
    op(0, 0, 0, 0, 1, m, v, 0, eh, ep);
  endtask
  task automatic tick();
    op(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic host(input bit wr, input logic [IDX_W-1:0] s, input logic [1:0] w,
                      input bit v, input bit st, input logic [47:0] m, input logic [2:0] f, input logic [2:0] p);
    @(negedge clk);
    host_req = 1; host_wr = wr; host_set = s; host_way = w;
    host_wr_valid = v; host_wr_static = st; host_wr_mac = m; host_wr_fid = f; host_wr_port = p;
    @(negedge clk);
    host_req = 0;
    for (int i = 0; i < 20 && !host_done; i++) @(negedge clk);
    chk(host_done, "R9 host_done", host_done, 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  localparam logic [47:0] MA = 48'h00a1_b2c3_d4e5, MB = 48'h0002_4466_8800;
  localparam logic [47:0] MS = 48'h0070_1111_2222, MD = 48'h0033_5577_99bb;
  localparam logic [47:0] ME = 48'h00de_adbe_ef01, MC = 48'h0000_1234_5600;

  function automatic logic [47:0] cmac(input int k);
    return MC ^ 48'(k) ^ (48'(k) << 6);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!look_done && !host_done && drop_cnt == 0, "R1 reset outputs", {look_done, host_done, drop_cnt}, 0);
    rst_n = 1;
    look(MA, 12'd5, 0, 0);                           // R1 empty table floods
    learn(MA, 12'd5, 3'd2);
    look(MA, 12'd5, 1, 3'd2);                        // R2 R5 hit after learn
    look(MA, 12'd6, 0, 0);                           // R4 other VLAN, other database
    host(0, hsh(3'd5, MA), 2'd0, 0, 0, 0, 0, 0);     // R3 R9 read at hashed set
    chk(host_rd_valid && !host_rd_static && host_rd_mac == MA, "R3 entry at hashed set way 0",
        host_rd_mac, MA);
    chk(host_rd_fid == 3'd5 && host_rd_port == 3'd2 && host_rd_age == 2'd3, "R9 read fields fid/port/age",
        {host_rd_fid, host_rd_port, host_rd_age}, {3'd5, 3'd2, 2'd3});
    learn(MA, 12'd5, 3'd4);
    look(MA, 12'd5, 1, 3'd4);                        // R5 refresh rewrites port
    ivl_mode = 0;
    learn(MB, 12'd7, 3'd1);
    look(MB, 12'd3, 1, 3'd1);                        // R4 shared database
    ivl_mode = 1;
    look(MB, 12'd3, 0, 0);                           // R4 per-VLAN database 3 differs
    host(1, hsh(3'd1, MS), 2'd3, 1, 1, MS, 3'd1, 3'd5);
    learn(MS, 12'd1, 3'd1);
    look(MS, 12'd1, 1, 3'd5);                        // R7 static not overwritten
    tick(); tick();
    look(MA, 12'd5, 1, 3'd4);                        // R8 survives two ticks
    tick();
    look(MA, 12'd5, 0, 0);                           // R8 gone after third tick
    look(MS, 12'd1, 1, 3'd5);                        // R7 static never aged
    op(1, MD, 12'd2, 3'd3, 0, 0, 0, 1, 0, 0);        // R12 learn with tick
    tick(); tick();
    look(MD, 12'd2, 1, 3'd3);                        // R12 age started at 3
    tick();
    look(MD, 12'd2, 0, 0);                           // R12 expired on third tick
    op(1, ME, 12'd4, 3'd6, 1, ME, 12'd4, 0, 0, 0);   // R11 same-cycle search sees old state
    look(ME, 12'd4, 1, 3'd6);                        // R11 visible afterwards
    // R10 host read held off by an active search
    @(negedge clk);
    host_req = 1; host_wr = 0; host_set = hsh(3'd4, ME); host_way = 0;
    look_valid = 1; look_mac = 48'h0099_0000_0001; look_vid = 12'd0; expq.push_back(4'd0);
    @(negedge clk); host_req = 0;
    chk(!host_done, "R10 deferred cycle 1", host_done, 0); expq.push_back(4'd0);
    @(negedge clk);
    chk(!host_done, "R10 deferred cycle 2", host_done, 0); expq.push_back(4'd0);
    @(negedge clk); look_valid = 0;
    chk(!host_done, "R10 deferred cycle 3", host_done, 0);
    @(negedge clk);
    chk(host_done, "R10 done one cycle after search drops", host_done, 1);
    chk(drop_cnt == 0, "R6 no drops in phase one", drop_cnt, 0);

    do_reset();
    for (int k = 0; k < 4; k++) learn(cmac(k), 12'd1, 3'(k));
    host(0, hsh(3'd1, cmac(0)), 2'd3, 0, 0, 0, 0, 0);
    chk(host_rd_valid && host_rd_mac == cmac(3) && host_rd_port == 3'd3, "R5 fourth learn in way 3",
        host_rd_mac, cmac(3));
    learn(cmac(4), 12'd1, 3'd4);
    chk(drop_cnt == 1, "R6 full set drop counted", drop_cnt, 1);
    look(cmac(4), 12'd1, 0, 0);                      // R6 not stored
    learn(cmac(0), 12'd1, 3'd7);
    chk(drop_cnt == 1, "R5 matching learn not dropped", drop_cnt, 1);
    look(cmac(0), 12'd1, 1, 3'd7);                   // R5 refresh in full set
    tick(); tick(); tick();
    learn(cmac(4), 12'd1, 3'd2);
    look(cmac(4), 12'd1, 1, 3'd2);                   // R8 aged ways freed
    chk(drop_cnt == 1, "R6 count unchanged after freed learn", drop_cnt, 1);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2 all lookups answered", expq.size(), 0);
    report();
  end
endmodule